// File: doc/BRIEF.md
# DRAM Refresh Scheduler (CAS-before-RAS)

This block keeps an asynchronous, multiplexed-address DRAM alive from the host side. A free-running interval timer adds one unit of refresh debt every refresh interval. The interval is chosen so that the whole row space is covered inside the retention period. For example, 1,024 rows in 16 ms gives one refresh every 15.6 µs. While debt is outstanding and no refresh is running, the block raises a request to the memory access arbiter. When the arbiter grants the bus, the block runs one refresh cycle and then retires one unit of debt.

The refresh cycle uses strobe ordering. CAS is pulled low first and held for a setup time. RAS then falls while CAS is still low, and CAS is kept low for a hold time. RAS is held low for at least its minimum low width and then returns high for the precharge time. In this sequence the device supplies the row from its own internal counter, so the block has no address port and never drives the address bus. WE is held high at all times, because WE low at the falling edge of RAS would select a test mode instead of a refresh.

Every timing minimum is given in nanoseconds and converted to clock cycles by rounding up, with a floor of one cycle. When the arbiter keeps the grant back, debt builds up to a parameter limit. A tick that arrives while debt is at the limit is lost, and the block flags that with a one-cycle overflow pulse.

Top module: `cbr_refresh_sched`

## Requirements
- R1: During and right after reset, ras_n_o, cas_n_o and we_n_o are 1, req_o, busy_o, done_o and ovf_o are 0, and debt_o is 0.
- R2: Debt rises by one at every TICK_C-th rising clock edge after reset is released. TICK_C is ceil(REFRESH_NS·1000/CLK_PS). The first rise therefore comes at edge TICK_C.
- R3: req_o is 1 exactly when debt_o is nonzero and busy_o is 0. A refresh starts only on an edge where both req_o and gnt_i are 1. A grant while req_o is 0 leaves busy_o, ras_n_o and cas_n_o unchanged.
- R4: After the start edge, cas_n_o is 0 and ras_n_o is 1 for CSR_C cycles. RAS never falls unless CAS was already low in the cycle before.
- R5: ras_n_o is then 0 for RLO_C = max(RAS_C, CHR_C) cycles. cas_n_o stays 0 for the first CHR_C of those cycles, then goes to 1 and stays there.
- R6: After that, ras_n_o and cas_n_o are both 1 for RP_C cycles while busy_o is 1. done_o is 1 in the last of these cycles only, and busy_o returns to 0 on the next edge.
- R7: we_n_o is 1 in every cycle.
- R8: On the edge that ends a refresh, debt falls by one. If a tick lands on that same edge, debt is unchanged.
- R9: Debt never exceeds PEND_MAX. A tick at PEND_MAX with no refresh ending on that edge leaves debt at PEND_MAX and makes ovf_o 1 for the following cycle.
- R10: Each cycle count above (CSR_C, CHR_C, RAS_C, RP_C) is ceil(ns·1000/CLK_PS), with a minimum of 1. This holds even when the nanosecond value does not divide evenly by the clock period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gnt_i | input | 1 | Bus grant from the access arbiter |
| req_o | output | 1 | Refresh bus request |
| busy_o | output | 1 | Refresh cycle in progress |
| done_o | output | 1 | One-cycle pulse in the last precharge cycle |
| ras_n_o | output | 1 | Row strobe, active low, registered |
| cas_n_o | output | 1 | Column strobe, active low, registered |
| we_n_o | output | 1 | Write enable, held high |
| debt_o | output | DW | Refresh intervals owed |
| ovf_o | output | 1 | Pulse when a tick is lost at saturation |

## Verification
The refresh sequence is started after grant delays drawn at random, from zero cycles up to beyond a full interval. These runs separate a design that times its phases from the grant from one whose phases drift with the accumulated debt. The bench also drives random grant pulses while no request is pending, to show that an unrequested grant cannot start a cycle. A long grant drought drives the debt into saturation, and the overflow pulses are compared tick by tick against the bench's own edge count. The sequence is then drained, which exercises the case where a tick and the end of a refresh fall on the same edge.

// File: rtl/cbr_pkg.sv
package cbr_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_CSETUP = 2'd1,
        PH_RLOW   = 2'd2,
        PH_PRECHG = 2'd3
    } phase_e;

    // nanoseconds to clock cycles, rounded up, never below one cycle
    function automatic int unsigned ns_to_cyc(input int unsigned ns, input int unsigned clk_ps);
        int unsigned c;
        c = (ns * 1000 + clk_ps - 1) / clk_ps;
        if (c == 0) c = 1;
        return c;
    endfunction

endpackage

// File: rtl/cbr_tick_timer.sv
module cbr_tick_timer #(
    parameter int unsigned TICK_CYC = 1560
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned TW = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1;

    typedef struct packed {
        logic [TW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d  = tmr_q;
        tick_o = (tmr_q.cnt == TW'(TICK_CYC - 1));
        if (tick_o) tmr_d.cnt = '0;
        else        tmr_d.cnt = tmr_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q <= '0;
        else        tmr_q <= tmr_d;
    end
endmodule

// File: rtl/cbr_debt_ctr.sv
module cbr_debt_ctr #(
    parameter int unsigned PEND_MAX = 8,
    localparam int unsigned DW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick_i,
    input  logic          done_i,
    output logic [DW-1:0] debt_o,
    output logic          ovf_o
);
    typedef struct packed {
        logic [DW-1:0] debt;
        logic          ovf;
    } debt_t;

    debt_t dq_q, dq_d;
    logic  full;

    always_comb begin
        dq_d     = dq_q;
        dq_d.ovf = 1'b0;
        full     = (dq_q.debt == DW'(PEND_MAX));
        if (tick_i && !done_i) begin
            if (full) dq_d.ovf  = 1'b1;
            else      dq_d.debt = dq_q.debt + 1'b1;
        end else if (!tick_i && done_i && dq_q.debt != '0) begin
            dq_d.debt = dq_q.debt - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) dq_q <= '0;
        else        dq_q <= dq_d;
    end

    assign debt_o = dq_q.debt;
    assign ovf_o  = dq_q.ovf;

    // R9
    debt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        debt_o <= DW'(PEND_MAX));
    // R9
    ovf_at_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> (debt_o == DW'(PEND_MAX)));
    // R8
    retire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && !tick_i && debt_o != '0) |=> (debt_o == $past(debt_o) - 1'b1));
endmodule

// File: rtl/cbr_strobe_seq.sv
module cbr_strobe_seq
    import cbr_pkg::*;
#(
    parameter int unsigned CSR_CYC = 1,
    parameter int unsigned RLO_CYC = 12,
    parameter int unsigned CHR_CYC = 3,
    parameter int unsigned RP_CYC  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic ras_n_o,
    output logic cas_n_o,
    output logic busy_o,
    output logic done_o
);
    localparam int unsigned M1   = (CSR_CYC > RLO_CYC) ? CSR_CYC : RLO_CYC;
    localparam int unsigned MAXC = (M1 > RP_CYC) ? M1 : RP_CYC;
    localparam int unsigned CW   = $clog2(MAXC + 1);

    typedef struct packed {
        phase_e        ph;
        logic [CW-1:0] cnt;
        logic          ras_n;
        logic          cas_n;
    } seq_t;

    seq_t sq_q, sq_d;

    always_comb begin
        sq_d = sq_q;
        unique case (sq_q.ph)
            PH_IDLE: begin
                if (start_i) begin
                    sq_d.ph  = PH_CSETUP;
                    sq_d.cnt = '0;
                end
            end
            PH_CSETUP: begin
                if (sq_q.cnt == CW'(CSR_CYC - 1)) begin
                    sq_d.ph  = PH_RLOW;
                    sq_d.cnt = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            PH_RLOW: begin
                if (sq_q.cnt == CW'(RLO_CYC - 1)) begin
                    sq_d.ph  = PH_PRECHG;
                    sq_d.cnt = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            PH_PRECHG: begin
                if (sq_q.cnt == CW'(RP_CYC - 1)) begin
                    sq_d.ph  = PH_IDLE;
                    sq_d.cnt = '0;
                end else begin
                    sq_d.cnt = sq_q.cnt + 1'b1;
                end
            end
            default: begin
                sq_d.ph  = PH_IDLE;
                sq_d.cnt = '0;
            end
        endcase
        // strobes decoded from the next phase, so the pins come straight from flops
        sq_d.ras_n = (sq_d.ph != PH_RLOW);
        sq_d.cas_n = !((sq_d.ph == PH_CSETUP) ||
                       ((sq_d.ph == PH_RLOW) && (sq_d.cnt < CW'(CHR_CYC))));
    end

    always_ff @(posedge clk) begin
        if (!rst_n) sq_q <= '{ph: PH_IDLE, cnt: '0, ras_n: 1'b1, cas_n: 1'b1};
        else        sq_q <= sq_d;
    end

    assign ras_n_o = sq_q.ras_n;
    assign cas_n_o = sq_q.cas_n;
    assign busy_o  = (sq_q.ph != PH_IDLE);
    assign done_o  = (sq_q.ph == PH_PRECHG) && (sq_q.cnt == CW'(RP_CYC - 1));

    // R4
    cbr_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));
    // R6
    prechg_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sq_q.ph == PH_PRECHG) |-> (ras_n_o && cas_n_o));
    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> (!done_o && !busy_o));
    // R3
    start_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R5
    cas_rise_in_rlow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(cas_n_o) && !ras_n_o) |=> (cas_n_o || ras_n_o));
endmodule

// File: rtl/cbr_refresh_sched.sv
module cbr_refresh_sched
    import cbr_pkg::*;
#(
    parameter int unsigned CLK_PS     = 10000,
    parameter int unsigned REFRESH_NS = 15600,
    parameter int unsigned T_CSR_NS   = 10,
    parameter int unsigned T_CHR_NS   = 25,
    parameter int unsigned T_RAS_NS   = 120,
    parameter int unsigned T_RP_NS    = 90,
    parameter int unsigned PEND_MAX   = 8,
    localparam int unsigned DW = $clog2(PEND_MAX + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          gnt_i,
    output logic          req_o,
    output logic          busy_o,
    output logic          done_o,
    output logic          ras_n_o,
    output logic          cas_n_o,
    output logic          we_n_o,
    output logic [DW-1:0] debt_o,
    output logic          ovf_o
);
    localparam int unsigned TICK_C = ns_to_cyc(REFRESH_NS, CLK_PS);
    localparam int unsigned CSR_C  = ns_to_cyc(T_CSR_NS, CLK_PS);
    localparam int unsigned CHR_C  = ns_to_cyc(T_CHR_NS, CLK_PS);
    localparam int unsigned RAS_C  = ns_to_cyc(T_RAS_NS, CLK_PS);
    localparam int unsigned RP_C   = ns_to_cyc(T_RP_NS, CLK_PS);
    localparam int unsigned RLO_C  = (RAS_C > CHR_C) ? RAS_C : CHR_C;

    logic tick;
    logic start;

    cbr_tick_timer #(.TICK_CYC(TICK_C)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    cbr_debt_ctr #(.PEND_MAX(PEND_MAX)) u_debt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_i (tick),
        .done_i (done_o),
        .debt_o (debt_o),
        .ovf_o  (ovf_o)
    );

    assign req_o = (debt_o != '0) && !busy_o;
    assign start = req_o && gnt_i;

    cbr_strobe_seq #(
        .CSR_CYC (CSR_C),
        .RLO_CYC (RLO_C),
        .CHR_CYC (CHR_C),
        .RP_CYC  (RP_C)
    ) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (start),
        .ras_n_o (ras_n_o),
        .cas_n_o (cas_n_o),
        .busy_o  (busy_o),
        .done_o  (done_o)
    );

    assign we_n_o = 1'b1;

    // R3
    no_start_without_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_o && !busy_o) |=> !busy_o);
    // R7
    we_high_at_ras_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ras_n_o) |-> (we_n_o && $past(we_n_o)));
endmodule

// File: tb/cbr_refresh_sched_test.sv
module cbr_refresh_sched_test;
    localparam int CLK_NS  = 10;
    localparam int CLK_PS  = CLK_NS * 1000;
    localparam int REF_NS  = 500;
    localparam int CSR_NS  = 15;
    localparam int CHR_NS  = 25;
    localparam int RAS_NS  = 95;
    localparam int RP_NS   = 52;
    localparam int PMAX    = 3;
    localparam int DW      = $clog2(PMAX + 1);

    function automatic int cyc(input int ns);
        int c;
        c = (ns * 1000 + CLK_PS - 1) / CLK_PS;
        return (c < 1) ? 1 : c;
    endfunction

    localparam int TICK = (REF_NS * 1000 + CLK_PS - 1) / CLK_PS;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic gnt = 1'b0;
    logic req, busy, done, ras_n, cas_n, we_n, ovf;
    logic [DW-1:0] debt;

    int n_chk = 0;
    int n_bad = 0;
    int edges = 0;
    bit finished = 0;

    always #(CLK_NS / 2) clk = ~clk;
    always @(posedge clk) if (rst_n) edges = edges + 1;

    cbr_refresh_sched #(
        .CLK_PS(CLK_PS), .REFRESH_NS(REF_NS), .T_CSR_NS(CSR_NS), .T_CHR_NS(CHR_NS),
        .T_RAS_NS(RAS_NS), .T_RP_NS(RP_NS), .PEND_MAX(PMAX)
    ) uut (
        .clk(clk), .rst_n(rst_n), .gnt_i(gnt), .req_o(req), .busy_o(busy),
        .done_o(done), .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n),
        .debt_o(debt), .ovf_o(ovf)
    );

    function automatic bit tick_at(input int e);
        return (e > 0) && (e % TICK == 0);
    endfunction

    function automatic int exp_rlo();
        return (cyc(RAS_NS) > cyc(CHR_NS)) ? cyc(RAS_NS) : cyc(CHR_NS);
    endfunction

    task automatic chk(input bit ok, input string rq, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", rq, act, exp, $time);
        end
    endtask

    task automatic run_refresh(input int delay);
        int csr, rlo, chr, rp, ndone, bad_order, we_bad, ph, cls, dbefore, dexp;
        bit done_last, seen_done;
        int spurious_bad;
        spurious_bad = 0;
        // R3: random grants while no request is pending must not start a cycle
        while (!req) begin
            bit g;
            g = 1'($urandom_range(0, 1));
            gnt = g;
            @(negedge clk);
            if (g && busy && !req) spurious_bad++;
        end
        gnt = 1'b0;
        chk(spurious_bad == 0, "R3 grant without request", spurious_bad, 0);
        repeat (delay) @(negedge clk);
        gnt = 1'b1;
        @(negedge clk);
        gnt = 1'b0;
        csr = 0; rlo = 0; chr = 0; rp = 0; ndone = 0; bad_order = 0; we_bad = 0;
        ph = 0; done_last = 0; seen_done = 0; dbefore = 0;
        while (busy) begin
            cls = !ras_n ? 2 : (!cas_n ? 1 : 3);
            if (cls < ph) bad_order++;
            if (cls == 2 && !cas_n && chr != rlo) bad_order++;
            ph = cls;
            if (cls == 1) csr++;
            if (cls == 2) begin rlo++; if (!cas_n) chr++; end
            if (cls == 3) rp++;
            if (!we_n) we_bad++;
            done_last = done;
            if (done) begin ndone++; dbefore = int'(debt); seen_done = 1; end
            @(negedge clk);
        end
        chk(csr == cyc(CSR_NS), "R4 CAS setup cycles (R10 rounding)", csr, cyc(CSR_NS));
        chk(bad_order == 0, "R4 strobe order", bad_order, 0);
        chk(rlo == exp_rlo(), "R5 RAS low cycles", rlo, exp_rlo());
        chk(chr == cyc(CHR_NS), "R5 CAS hold cycles", chr, cyc(CHR_NS));
        chk(rp == cyc(RP_NS), "R6 precharge cycles (R10 rounding)", rp, cyc(RP_NS));
        chk(ndone == 1 && done_last, "R6 done pulse", ndone, 1);
        chk(we_bad == 0, "R7 WE high", we_bad, 0);
        dexp = dbefore - 1 + (tick_at(edges) ? 1 : 0);
        if (seen_done) chk(int'(debt) == dexp, "R8 debt retire", int'(debt), dexp);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int early, bz, ovf_bad, dbad;
        void'($urandom(32'd2024));
        repeat (4) @(negedge clk);
        // R1 reset state
        chk(ras_n && cas_n && we_n, "R1 strobes high in reset", {ras_n, cas_n, we_n}, 7);
        chk(!req && !busy && !done && !ovf && debt == 0, "R1 status idle in reset",
            {req, busy, done, ovf}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ras_n && cas_n && !req && debt == 0, "R1 idle after reset", int'(debt), 0);
        // R2 first tick; R3 unrequested grants ignored
        early = 0; bz = 0;
        while (edges < TICK) begin
            gnt = (edges >= 2 && edges <= 8);
            @(negedge clk);
            if (edges < TICK && (req || debt != 0)) early++;
            if (busy || !ras_n || !cas_n) bz++;
        end
        gnt = 1'b0;
        chk(early == 0, "R2 no debt before first tick", early, 0);
        chk(bz == 0, "R3 grant ignored with no request", bz, 0);
        chk(req && debt == 1, "R2 debt after edge TICK", int'(debt), 1);
        // directed: immediate grant
        run_refresh(0);
        // random grant latencies
        for (int i = 0; i < 20; i++) run_refresh(int'($urandom_range(0, 60)));
        // saturation: withhold grant
        while (debt != DW'(PMAX)) @(negedge clk);
        ovf_bad = 0; dbad = 0;
        for (int i = 0; i < 3 * TICK; i++) begin
            @(negedge clk);
            if (ovf != tick_at(edges)) ovf_bad++;
            if (debt != DW'(PMAX)) dbad++;
        end
        chk(ovf_bad == 0, "R9 overflow pulses on lost ticks", ovf_bad, 0);
        chk(dbad == 0, "R9 debt held at limit", dbad, 0);
        // drain
        for (int i = 0; i < 10 && debt != 0; i++) run_refresh(0);
        chk(debt <= 1, "R8 debt drained", int'(debt), 0);
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule